// File: doc/BRIEF.md
# GCM Counter and Length Block Preparation Unit

This unit does the bookkeeping that sits around an AES core and a GHASH multiplier in Galois/Counter Mode. When a session starts it takes a 96-bit nonce and builds the pre-counter block J0. It keeps J0 for the final tag encryption and also presents the first data counter. While the session runs it counts the additional-data bytes and the ciphertext bytes that pass it. When the session finishes it emits the 128-bit length block that feeds the last GHASH multiplication.

The unit accepts only 12-byte nonces, because other nonce lengths would need a GHASH pass over the nonce. Any other length raises an error flag and opens no session. The unit also checks the requested tag length when a session starts. A ciphertext-channel beat can be marked as preparation traffic. This covers the encryption of the all-zero block that yields the hash subkey, and such a beat is never counted.

Top module: `gcm_setup_unit`

## Requirements
- R1: After reset, every output is zero: both valid flags, both error flags, the overflow flag, and all three 128-bit blocks.
- R2: One cycle after a load with `nonce_len` equal to 12, `j0_blk` equals the nonce in bits 127:32, with the nonce's first byte in bits 127:120, and the value 32'h0000_0001 in bits 31:0.
- R3: In the same cycle, `ctr_valid` is 1 and `ctr_blk` equals J0 with bits 31:0 incremented by one as an unsigned 32-bit big-endian number (modulo 2^32), with bits 127:32 unchanged.
- R4: Once accepted, J0 and the first counter stay unchanged through counting and through finish, until the next load.
- R5: A load with any other `nonce_len` sets `nonce_err`, clears `ctr_valid`, `j0_blk` and `ctr_blk`, and opens no session. Later beats and finish requests then have no effect on `len_valid` or `len_blk`.
- R6: At every load, `tag_err` is set when `tag_len` is below 12 or above 16, and cleared otherwise.
- R7: While a session is open, each `aad_valid` beat adds `aad_bytes` (0 to 16) to the additional-data count, and each `ct_valid` beat adds `ct_bytes` to the ciphertext count.
- R8: A ciphertext beat with `ct_prep` high is not counted.
- R9: A `finish` in an open session sets `len_valid` one cycle later. `len_blk[127:64]` is then the additional-data length in bits and `len_blk[63:0]` is the ciphertext length in bits, both most significant byte first. Beats in the finish cycle and after it are not counted, and the session closes.
- R10: Each count saturates at 2^CNT_W-1. A beat that would go past that limit leaves the count at the limit and sets `len_ovf`, which stays set until the next load.
- R11: A load has priority over `finish` and over beats in the same cycle. It clears both counts, `len_valid`, `len_blk` and `len_ovf`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Start a session with the nonce and lengths below |
| nonce_len | input | LEN_W | Nonce length in bytes |
| nonce | input | 96 | Nonce, first byte in bits 95:88 |
| tag_len | input | TAG_W | Requested tag length in bytes |
| aad_valid | input | 1 | Additional-data beat present |
| aad_bytes | input | BEAT_W | Bytes in the additional-data beat |
| ct_valid | input | 1 | Ciphertext beat present |
| ct_bytes | input | BEAT_W | Bytes in the ciphertext beat |
| ct_prep | input | 1 | Ciphertext beat is subkey preparation, not counted |
| finish | input | 1 | Close the session and build the length block |
| j0_blk | output | 128 | Held pre-counter block for tag encryption |
| ctr_blk | output | 128 | First data counter |
| ctr_valid | output | 1 | J0 and counter are valid |
| nonce_err | output | 1 | Last load had an unsupported nonce length |
| tag_err | output | 1 | Last load had a tag length outside 12..16 |
| len_valid | output | 1 | Length block is valid |
| len_blk | output | 128 | Length block for the final GHASH step |
| len_ovf | output | 1 | A byte count saturated |

## Verification
The bench checks the low word of J0 against a fixed 1 and the counter against J0 plus one. A design that confused byte order or incremented the wrong word would put the increment in the nonce bits. A nonce of all ones, loaded with 16-byte and other illegal lengths, checks that no counter appears after a rejection and that beats after a rejection leave the length block alone. Zero-byte beats, preparation beats, beats in the finish cycle and a load that collides with finish and beats check that nothing stray is counted. Driving the count past its limit shows whether a design wraps instead of saturating, or sets the overflow flag when the count only reaches the limit.

// File: rtl/gcm_setup_pkg.sv
package gcm_setup_pkg;
    localparam int BLK_W      = 128;
    localparam int WORD_W     = 32;
    localparam int NONCE_W    = 96;
    localparam int HALF_W     = 64;
    localparam int NONCE_OK   = 12;
    localparam int TAG_LO     = 12;
    localparam int TAG_HI     = 16;

    typedef logic [BLK_W-1:0] blk_t;

    typedef struct packed {
        logic [NONCE_W-1:0] fixed;
        logic [WORD_W-1:0]  count;
    } ctr_blk_t;

    typedef enum logic [1:0] {
        SES_IDLE = 2'd0,
        SES_RUN  = 2'd1,
        SES_DONE = 2'd2,
        SES_BAD  = 2'd3
    } ses_e;

    function automatic ctr_blk_t make_j0(input logic [NONCE_W-1:0] n);
        ctr_blk_t b;
        b.fixed = n;
        b.count = {{(WORD_W-1){1'b0}}, 1'b1};
        return b;
    endfunction

    function automatic ctr_blk_t bump_low(input ctr_blk_t b);
        ctr_blk_t r;
        r.fixed = b.fixed;
        r.count = b.count + {{(WORD_W-1){1'b0}}, 1'b1};
        return r;
    endfunction
endpackage

// File: rtl/gcm_j0_former.sv
module gcm_j0_former
    import gcm_setup_pkg::*;
#(
    parameter int LEN_W = 5,
    parameter int TAG_W = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [LEN_W-1:0]   nonce_len,
    input  logic [NONCE_W-1:0] nonce,
    input  logic [TAG_W-1:0]   tag_len,
    output logic               accept,
    output blk_t               j0_blk,
    output blk_t               ctr_blk,
    output logic               ctr_valid,
    output logic               nonce_err,
    output logic               tag_err
);
    ctr_blk_t j0_q, ctr_q;
    ctr_blk_t j0_new;

    assign accept = load && (32'(nonce_len) == NONCE_OK);
    assign j0_new = make_j0(nonce);

    always_ff @(posedge clk) begin
        if (rst) begin
            j0_q      <= '0;
            ctr_q     <= '0;
            ctr_valid <= 1'b0;
            nonce_err <= 1'b0;
            tag_err   <= 1'b0;
        end else if (load) begin
            tag_err <= (32'(tag_len) < TAG_LO) || (32'(tag_len) > TAG_HI);
            if (accept) begin
                j0_q      <= j0_new;
                ctr_q     <= bump_low(j0_new);
                ctr_valid <= 1'b1;
                nonce_err <= 1'b0;
            end else begin
                j0_q      <= '0;
                ctr_q     <= '0;
                ctr_valid <= 1'b0;
                nonce_err <= 1'b1;
            end
        end
    end

    assign j0_blk  = j0_q;
    assign ctr_blk = ctr_q;

    p_j0_tail_r2: assert property (@(posedge clk) disable iff (rst)
        ctr_valid |-> (j0_blk[WORD_W-1:0] == 32'd1))
        else $error("j0 low word not 1");

    p_ctr_step_r3: assert property (@(posedge clk) disable iff (rst)
        ctr_valid |-> (ctr_blk[BLK_W-1:WORD_W] == j0_blk[BLK_W-1:WORD_W]
                       && ctr_blk[WORD_W-1:0] == j0_blk[WORD_W-1:0] + 32'd1))
        else $error("counter not j0+1");

    p_err_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(ctr_valid && nonce_err))
        else $error("counter valid with nonce error");
endmodule

// File: rtl/gcm_byte_tally.sv
module gcm_byte_tally #(
    parameter int CNT_W  = 61,
    parameter int BEAT_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              add_en,
    input  logic [BEAT_W-1:0] add_val,
    output logic [CNT_W-1:0]  cnt,
    output logic              ovf
);
    localparam logic [CNT_W-1:0] MAX_C = {CNT_W{1'b1}};

    logic [CNT_W:0] sum;
    assign sum = {1'b0, cnt} + (CNT_W+1)'(add_val);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (add_en) begin
            if (sum[CNT_W]) begin
                cnt <= MAX_C;
                ovf <= 1'b1;
            end else begin
                cnt <= sum[CNT_W-1:0];
            end
        end
    end

    p_no_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        ovf |-> (cnt == MAX_C))
        else $error("overflow flag without saturated count");

    p_monotone_r7: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt >= $past(cnt)))
        else $error("count decreased without clear");
endmodule

// File: rtl/gcm_len_pack.sv
module gcm_len_pack
    import gcm_setup_pkg::*;
#(
    parameter int CNT_W = 61
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             take,
    input  logic [CNT_W-1:0] aad_cnt,
    input  logic [CNT_W-1:0] ct_cnt,
    output logic             len_valid,
    output blk_t             len_blk
);
    logic [HALF_W-1:0] aad_bits, ct_bits;
    assign aad_bits = HALF_W'(aad_cnt) << 3;
    assign ct_bits  = HALF_W'(ct_cnt) << 3;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            len_valid <= 1'b0;
            len_blk   <= '0;
        end else if (take) begin
            len_valid <= 1'b1;
            len_blk   <= {aad_bits, ct_bits};
        end
    end
endmodule

// File: rtl/gcm_setup_unit.sv
module gcm_setup_unit
    import gcm_setup_pkg::*;
#(
    parameter int CNT_W  = 61,
    parameter int BEAT_W = 5,
    parameter int LEN_W  = 5,
    parameter int TAG_W  = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [LEN_W-1:0]   nonce_len,
    input  logic [95:0]        nonce,
    input  logic [TAG_W-1:0]   tag_len,
    input  logic               aad_valid,
    input  logic [BEAT_W-1:0]  aad_bytes,
    input  logic               ct_valid,
    input  logic [BEAT_W-1:0]  ct_bytes,
    input  logic               ct_prep,
    input  logic               finish,
    output logic [127:0]       j0_blk,
    output logic [127:0]       ctr_blk,
    output logic               ctr_valid,
    output logic               nonce_err,
    output logic               tag_err,
    output logic               len_valid,
    output logic [127:0]       len_blk,
    output logic               len_ovf
);
    localparam int N_CH = 2;

    ses_e ses_q;
    logic accept, running, take, count_ok;
    logic [N_CH-1:0]   ch_en, ch_ovf;
    logic [BEAT_W-1:0] ch_val [N_CH];
    logic [CNT_W-1:0]  ch_cnt [N_CH];

    gcm_j0_former #(.LEN_W(LEN_W), .TAG_W(TAG_W)) u_j0 (
        .clk(clk), .rst(rst), .load(load), .nonce_len(nonce_len),
        .nonce(nonce), .tag_len(tag_len), .accept(accept),
        .j0_blk(j0_blk), .ctr_blk(ctr_blk), .ctr_valid(ctr_valid),
        .nonce_err(nonce_err), .tag_err(tag_err)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ses_q <= SES_IDLE;
        end else if (load) begin
            ses_q <= accept ? SES_RUN : SES_BAD;
        end else if (running && finish) begin
            ses_q <= SES_DONE;
        end
    end

    assign running  = (ses_q == SES_RUN);
    assign count_ok = running && !load && !finish;
    assign take     = running && finish && !load;

    assign ch_en[0]  = count_ok && aad_valid;
    assign ch_val[0] = aad_bytes;
    assign ch_en[1]  = count_ok && ct_valid && !ct_prep;
    assign ch_val[1] = ct_bytes;

    for (genvar g = 0; g < N_CH; g++) begin : g_tally
        gcm_byte_tally #(.CNT_W(CNT_W), .BEAT_W(BEAT_W)) u_tally (
            .clk(clk), .rst(rst), .clr(load), .add_en(ch_en[g]),
            .add_val(ch_val[g]), .cnt(ch_cnt[g]), .ovf(ch_ovf[g])
        );
    end

    assign len_ovf = |ch_ovf;

    gcm_len_pack #(.CNT_W(CNT_W)) u_pack (
        .clk(clk), .rst(rst), .clr(load), .take(take),
        .aad_cnt(ch_cnt[0]), .ct_cnt(ch_cnt[1]),
        .len_valid(len_valid), .len_blk(len_blk)
    );

    p_j0_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (ctr_valid && !load) |=> ($stable(j0_blk) && $stable(ctr_blk)))
        else $error("j0 changed without load");

    p_len_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (len_valid && !load) |=> (len_valid && $stable(len_blk)))
        else $error("length block changed after finish");

    p_no_len_bad_r5: assert property (@(posedge clk) disable iff (rst)
        nonce_err |-> !len_valid)
        else $error("length block after rejected nonce");

    p_load_clears_r11: assert property (@(posedge clk) disable iff (rst)
        load |=> (!len_valid && !len_ovf))
        else $error("load did not clear length state");
endmodule

// File: tb/gcm_setup_unit_tb.sv
module gcm_setup_unit_tb;
    localparam int CW = 8;
    localparam longint MAXC = (64'd1 << CW) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic load = 1'b0;
    logic [4:0] nonce_len = '0;
    logic [95:0] nonce = '0;
    logic [4:0] tag_len = '0;
    logic aad_valid = 1'b0, ct_valid = 1'b0, ct_prep = 1'b0, finish = 1'b0;
    logic [4:0] aad_bytes = '0, ct_bytes = '0;
    logic [127:0] j0_blk, ctr_blk, len_blk;
    logic ctr_valid, nonce_err, tag_err, len_valid, len_ovf;

    always #4 clk = ~clk;

    gcm_setup_unit #(.CNT_W(CW)) u_dut (
        .clk(clk), .rst(rst), .load(load), .nonce_len(nonce_len), .nonce(nonce),
        .tag_len(tag_len), .aad_valid(aad_valid), .aad_bytes(aad_bytes),
        .ct_valid(ct_valid), .ct_bytes(ct_bytes), .ct_prep(ct_prep),
        .finish(finish), .j0_blk(j0_blk), .ctr_blk(ctr_blk),
        .ctr_valid(ctr_valid), .nonce_err(nonce_err), .tag_err(tag_err),
        .len_valid(len_valid), .len_blk(len_blk), .len_ovf(len_ovf)
    );

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // behavioural reference
    bit m_open, m_cv, m_ne, m_te, m_lv, m_ovf;
    logic [127:0] m_j0, m_ctr, m_len;
    longint m_aad, m_ct;

    always @(posedge clk) begin
        if (rst) begin
            m_open = 0; m_cv = 0; m_ne = 0; m_te = 0; m_lv = 0; m_ovf = 0;
            m_j0 = '0; m_ctr = '0; m_len = '0; m_aad = 0; m_ct = 0;
        end else if (load) begin
            m_te = (tag_len < 12) || (tag_len > 16);
            m_aad = 0; m_ct = 0; m_ovf = 0; m_lv = 0; m_len = '0;
            if (nonce_len == 12) begin
                m_j0 = {nonce, 32'd1};
                m_ctr = {nonce, 32'd2};
                m_cv = 1; m_ne = 0; m_open = 1;
            end else begin
                m_j0 = '0; m_ctr = '0; m_cv = 0; m_ne = 1; m_open = 0;
            end
        end else if (m_open && finish) begin
            m_lv = 1;
            m_len = {64'(m_aad * 8), 64'(m_ct * 8)};
            m_open = 0;
        end else if (m_open) begin
            if (aad_valid) begin
                m_aad = m_aad + longint'(aad_bytes);
                if (m_aad > MAXC) begin m_aad = MAXC; m_ovf = 1; end
            end
            if (ct_valid && !ct_prep) begin
                m_ct = m_ct + longint'(ct_bytes);
                if (m_ct > MAXC) begin m_ct = MAXC; m_ovf = 1; end
            end
        end
    end

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("R2 j0", j0_blk, m_j0);
            chk("R3 ctr", ctr_blk, m_ctr);
            chk("R3 ctr_valid", 128'(ctr_valid), 128'(m_cv));
            chk("R5 nonce_err", 128'(nonce_err), 128'(m_ne));
            chk("R6 tag_err", 128'(tag_err), 128'(m_te));
            chk("R9 len_valid", 128'(len_valid), 128'(m_lv));
            chk("R9 len_blk", len_blk, m_len);
            chk("R10 len_ovf", 128'(len_ovf), 128'(m_ovf));
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle();
        load = 0; finish = 0; aad_valid = 0; ct_valid = 0; ct_prep = 0;
        aad_bytes = '0; ct_bytes = '0;
    endtask

    task automatic do_load(input int len, input logic [95:0] n, input int tl);
        load = 1; nonce_len = 5'(len); nonce = n; tag_len = 5'(tl);
        step(); idle();
    endtask

    task automatic aad_beat(input int b);
        aad_valid = 1; aad_bytes = 5'(b); step(); idle();
    endtask

    task automatic ct_beat(input int b, input bit prep);
        ct_valid = 1; ct_bytes = 5'(b); ct_prep = prep; step(); idle();
    endtask

    task automatic do_finish();
        finish = 1; step(); idle();
    endtask

    task automatic summary();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        logic [95:0] na;
        na = 96'h00112233_44556677_8899aabb;
        step(); step(); step();
        rst = 0;
        // R1 reset state
        chk("R1 reset j0", j0_blk, '0);
        chk("R1 reset flags", 128'({ctr_valid, nonce_err, tag_err, len_valid, len_ovf}), '0);
        chk("R1 reset len", len_blk, '0);

        // R2 R3 R7 R8: normal session
        do_load(12, na, 16);
        chk("R2 j0 layout", j0_blk, {na, 32'h0000_0001});
        chk("R3 first counter", ctr_blk, {na, 32'h0000_0002});
        aad_beat(16); aad_beat(16); aad_beat(5); aad_beat(0);
        ct_beat(16, 0); ct_beat(7, 0); ct_beat(16, 1); ct_beat(0, 0);
        // beat in finish cycle is not counted (R9)
        finish = 1; aad_valid = 1; aad_bytes = 5'd9; step(); idle();
        chk("R7 aad bits", 128'(len_blk[127:64]), 128'(37 * 8));
        chk("R8 prep not counted", 128'(len_blk[63:0]), 128'(23 * 8));
        aad_beat(16);
        chk("R9 beats after finish ignored", len_blk, {64'(37*8), 64'(23*8)});
        chk("R4 j0 held after finish", j0_blk, {na, 32'h0000_0001});

        // R5 R6: rejected nonce
        do_load(16, {96{1'b1}}, 8);
        chk("R5 nonce_err", 128'({nonce_err, ctr_valid}), 128'(2'b10));
        chk("R6 tag below range", 128'(tag_err), 128'(1));
        aad_beat(16); do_finish();
        chk("R5 no length after reject", 128'(len_valid), 128'(0));
        do_load(0, na, 17);
        chk("R6 tag above range", 128'(tag_err), 128'(1));
        do_load(11, na, 12);
        chk("R5 short nonce", 128'(nonce_err), 128'(1));

        // all-ones nonce, tag 12
        do_load(12, {96{1'b1}}, 12);
        chk("R3 all-ones nonce counter", ctr_blk, {{96{1'b1}}, 32'd2});
        chk("R6 tag 12 ok", 128'(tag_err), 128'(0));

        // R10 saturation
        do_load(12, na, 13);
        for (int k = 0; k < 15; k++) aad_beat(16);
        aad_beat(15);
        chk("R10 reaching limit no ovf", 128'(len_ovf), 128'(0));
        aad_beat(1);
        chk("R10 past limit ovf", 128'(len_ovf), 128'(1));
        ct_beat(3, 0);
        do_finish();
        chk("R10 saturated length", len_blk, {64'(MAXC*8), 64'(3*8)});

        // R11 priority of load
        do_load(12, na, 14);
        aad_beat(10); ct_beat(4, 0);
        load = 1; nonce_len = 5'd12; finish = 1; aad_valid = 1; aad_bytes = 5'd6;
        ct_valid = 1; ct_bytes = 5'd6; step(); idle();
        chk("R11 load beats finish", 128'({len_valid, len_ovf}), 128'(0));
        do_finish();
        chk("R11 counts cleared", len_blk, '0);
        chk("R4 j0 held", j0_blk, {na, 32'h0000_0001});

        step(); step();
        summary();
    end
endmodule